// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive monitor for the command and address bus of a four-bank synchronous DRAM. Each clock it turns the chip-select, row strobe, column strobe, write enable and clock enable levels into a command, and it follows every bank through idle, open and closing states. A small counter per bank, plus two shared counters, measure the clocks since the last relevant command. Any command that breaks a state rule or comes too early sets a sticky error flag and latches a code that names the rule.

A one-bit timing-set select chooses between the faster clock set and the 100 MHz set, which allows shorter row-to-column, row-active and precharge windows. The monitor never drives the bus. It is meant to sit beside a memory controller in simulation or in silicon debug logic, and software or a bench clears the flag through a synchronous clear input.

Top module: `sdram_cmd_checker`

## Requirements
- R1: `cmd_o` follows the current bus combinationally. With clock enable low it is NOP (1). With chip-select high it is DESELECT (0). Otherwise {RAS,CAS,WE} selects the command: 011 ACTIVE (2), 101 READ (3), 100 WRITE (4), 010 PRECHARGE (5), 001 REFRESH (6), 000 MODE SET (7), 110 BURST STOP (8), 111 NOP (1).
- R2: Bank b reports its state on `bank_state_o[2b+1:2b]` as 0 idle, 1 open or 2 closing. An ACTIVE opens the bank. A PRECHARGE of an open bank makes it closing, and it reads idle from the edge that samples the precharge-time count onward.
- R3: A PRECHARGE with A10 high closes every open bank. With A10 low it closes only the bank on BA.
- R4: A READ or WRITE to an open bank fewer than 3 clocks after its ACTIVE (2 clocks with `slow_i`=1) gives code 2.
- R5: An ACTIVE fewer than 2 clocks after the previous ACTIVE to any bank gives code 3.
- R6: A PRECHARGE of an open bank fewer than 6 clocks after its ACTIVE (5 with `slow_i`=1) gives code 4.
- R7: An ACTIVE to a bank fewer than 3 clocks after its PRECHARGE (2 with `slow_i`=1) gives code 5.
- R8: Any command other than DESELECT or NOP fewer than 2 clocks after a MODE SET gives code 6.
- R9: An ACTIVE to an open bank, or a READ or WRITE to a bank that is not open, gives code 1.
- R10: A REFRESH or MODE SET while any bank is open gives code 7.
- R11: READ and WRITE commands on consecutive clocks to an open bank that meets R4 raise no error.
- R12: `err_o` rises on the edge after the offending command and stays high until `clr_i` is sampled high, which clears both flag and code. Only the first error's code is kept. When several rules break in one cycle, the code is chosen in this order: 6, 1, 7, 2, 4, 5, 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the error flag and code |
| slow_i | input | 1 | Timing-set select: 1 selects the 100 MHz set |
| cke_i | input | 1 | Clock enable from the bus |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Address bit 10, the all-banks flag on precharge |
| cmd_o | output | 4 | Decoded command of the current cycle |
| bank_state_o | output | 8 | Two-bit state per bank |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 3 | Code of the first error, 0 when none |

## Verification
A wrong bank state shows on `bank_state_o` on the edge after the command that caused it. It also surfaces one edge after the next command to that bank, as a spurious or missing code 1. A counter that starts or saturates at the wrong value shows only when a command lands exactly on a window boundary. For that reason each spacing rule is exercised one clock short of its limit and at the limit itself. A fault in the priority or the latch shows as a wrong code after two errors in one cycle or in a row.

// File: rtl/sdc_pkg.sv
// Shared types for the SDRAM command timing checker.
// Assumes a single command per clock on the monitored bus.
package sdc_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_REF   = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_BST   = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_e;

    localparam logic [2:0] E_NONE  = 3'd0;
    localparam logic [2:0] E_STATE = 3'd1;
    localparam logic [2:0] E_TRCD  = 3'd2;
    localparam logic [2:0] E_TRRD  = 3'd3;
    localparam logic [2:0] E_TRAS  = 3'd4;
    localparam logic [2:0] E_TRP   = 3'd5;
    localparam logic [2:0] E_TMRD  = 3'd6;
    localparam logic [2:0] E_BUSY  = 3'd7;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
// Turns the strobe levels of one bus cycle into a command.
// Assumes clock enable low means the cycle carries no command.
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);

    // Map strobe pattern to command
    always_comb begin
        if (!cke_i) begin
            cmd_o = CMD_NOP;
        end else if (cs_n_i) begin
            cmd_o = CMD_DESEL;
        end else begin
            case ({ras_n_i, cas_n_i, we_n_i})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_MRS;
                3'b110:  cmd_o = CMD_BST;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdc_bank_track.sv
// Follows one bank through idle, open and closing, and flags the
// per-bank rule breaks of the current cycle's command.
// Assumes the limits are smaller than the counter's saturation value.
module sdc_bank_track
    import sdc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd_i,
    input  logic             sel_i,
    input  logic             all_i,
    input  logic [CNT_W-1:0] trcd_i,
    input  logic [CNT_W-1:0] tras_i,
    input  logic [CNT_W-1:0] trp_i,
    output bank_e            state_o,
    output logic             v_state_o,
    output logic             v_trcd_o,
    output logic             v_tras_o,
    output logic             v_trp_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    bank_e            st_q;
    logic [CNT_W-1:0] age_q;
    logic             col_cmd;
    logic             pre_hit;

    assign col_cmd = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
    assign pre_hit = (cmd_i == CMD_PRE) && (sel_i || all_i);
    assign state_o = st_q;

    // Per-bank rule checks for the command on the bus now
    always_comb begin
        v_state_o = sel_i && (((cmd_i == CMD_ACT) && (st_q == BK_OPEN)) ||
                              (col_cmd && (st_q != BK_OPEN)));
        v_trcd_o  = sel_i && col_cmd && (st_q == BK_OPEN) && (age_q < trcd_i);
        v_tras_o  = pre_hit && (st_q == BK_OPEN) && (age_q < tras_i);
        v_trp_o   = sel_i && (cmd_i == CMD_ACT) && (st_q == BK_CLOSING) &&
                    (age_q < trp_i);
    end

    // Bank state and clocks since its last ACTIVE or PRECHARGE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            age_q <= CNT_MAX;
        end else if (sel_i && (cmd_i == CMD_ACT)) begin
            st_q  <= BK_OPEN;
            age_q <= CNT_ONE;
        end else if (pre_hit && (st_q == BK_OPEN)) begin
            st_q  <= BK_CLOSING;
            age_q <= CNT_ONE;
        end else begin
            if ((st_q == BK_CLOSING) && (age_q >= trp_i)) begin
                st_q <= BK_IDLE;
            end
            if (age_q != CNT_MAX) begin
                age_q <= age_q + CNT_ONE;
            end
        end
    end

    // R2
    open_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && cmd_i == CMD_ACT) |=> (state_o == BK_OPEN));

    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd3));

    // R3
    closes_on_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && state_o == BK_OPEN && !(sel_i && cmd_i == CMD_ACT))
        |=> (state_o == BK_CLOSING));

endmodule

// File: rtl/sdc_err_latch.sv
// Holds the sticky error flag and the code of the first error.
// Assumes at most one clear per cycle; clear wins over a new error.
module sdc_err_latch
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       v_state_i,
    input  logic       v_trcd_i,
    input  logic       v_trrd_i,
    input  logic       v_tras_i,
    input  logic       v_trp_i,
    input  logic       v_tmrd_i,
    input  logic       v_busy_i,
    output logic       err_o,
    output logic [2:0] code_o
);

    logic [2:0] pick;

    // Fixed priority among errors raised in the same cycle
    always_comb begin
        if (v_tmrd_i)       pick = E_TMRD;
        else if (v_state_i) pick = E_STATE;
        else if (v_busy_i)  pick = E_BUSY;
        else if (v_trcd_i)  pick = E_TRCD;
        else if (v_tras_i)  pick = E_TRAS;
        else if (v_trp_i)   pick = E_TRP;
        else if (v_trrd_i)  pick = E_TRRD;
        else                pick = E_NONE;
    end

    // Latch the first error until cleared
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            err_o  <= 1'b0;
            code_o <= E_NONE;
        end else if (!err_o && (pick != E_NONE)) begin
            err_o  <= 1'b1;
            code_o <= pick;
        end
    end

    // R12
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_i) |=> err_o);

    // R12
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_i) |=> $stable(code_o));

    // R12
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!err_o && code_o == E_NONE));

    // R12
    code_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (code_o != E_NONE));

endmodule

// File: rtl/sdram_cmd_checker.sv
// Passive monitor of an SDRAM command bus: decodes commands, tracks each
// bank and latches the first broken state or spacing rule.
// Assumes commands are sampled on the rising clock edge, one per cycle.
module sdram_cmd_checker
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int T_RCD_FAST  = 3,
    parameter int T_RCD_SLOW  = 2,
    parameter int T_RAS_FAST  = 6,
    parameter int T_RAS_SLOW  = 5,
    parameter int T_RP_FAST   = 3,
    parameter int T_RP_SLOW   = 2,
    parameter int T_RRD       = 2,
    parameter int T_MRD       = 2,
    localparam int BA_W       = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   slow_i,
    input  logic                   cke_i,
    input  logic                   cs_n_i,
    input  logic                   ras_n_i,
    input  logic                   cas_n_i,
    input  logic                   we_n_i,
    input  logic [BA_W-1:0]        ba_i,
    input  logic                   a10_i,
    output logic [3:0]             cmd_o,
    output logic [2*NUM_BANKS-1:0] bank_state_o,
    output logic                   err_o,
    output logic [2:0]             err_code_o
);

    localparam int T_MAX = imax(imax(imax(T_RCD_FAST, T_RCD_SLOW),
                                     imax(T_RAS_FAST, T_RAS_SLOW)),
                                imax(imax(T_RP_FAST, T_RP_SLOW),
                                     imax(T_RRD, T_MRD)));
    localparam int CNT_W = $clog2(T_MAX + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] RRD_C   = CNT_W'(T_RRD);
    localparam logic [CNT_W-1:0] MRD_C   = CNT_W'(T_MRD);

    cmd_e                   cmd;
    logic [CNT_W-1:0]       trcd, tras, trp;
    logic [CNT_W-1:0]       act_gap_q, mrs_gap_q;
    logic [NUM_BANKS-1:0]   bk_state, bk_trcd, bk_tras, bk_trp, bk_open;
    logic                   v_trrd, v_tmrd, v_busy;

    sdc_cmd_decode u_dec (
        .cke_i   (cke_i),
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .cmd_o   (cmd)
    );

    assign cmd_o = cmd;

    // Pick the window lengths of the selected timing set
    always_comb begin
        trcd = slow_i ? CNT_W'(T_RCD_SLOW) : CNT_W'(T_RCD_FAST);
        tras = slow_i ? CNT_W'(T_RAS_SLOW) : CNT_W'(T_RAS_FAST);
        trp  = slow_i ? CNT_W'(T_RP_SLOW)  : CNT_W'(T_RP_FAST);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_e st;
        sdc_bank_track #(.CNT_W(CNT_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_i     (cmd),
            .sel_i     (ba_i == BA_W'(b)),
            .all_i     (a10_i),
            .trcd_i    (trcd),
            .tras_i    (tras),
            .trp_i     (trp),
            .state_o   (st),
            .v_state_o (bk_state[b]),
            .v_trcd_o  (bk_trcd[b]),
            .v_tras_o  (bk_tras[b]),
            .v_trp_o   (bk_trp[b])
        );
        assign bank_state_o[2*b +: 2] = st;
        assign bk_open[b] = (st == BK_OPEN);
    end

    // Clocks since the last ACTIVE to any bank and since the last mode set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_gap_q <= CNT_MAX;
            mrs_gap_q <= CNT_MAX;
        end else begin
            if (cmd == CMD_ACT)           act_gap_q <= CNT_ONE;
            else if (act_gap_q != CNT_MAX) act_gap_q <= act_gap_q + CNT_ONE;
            if (cmd == CMD_MRS)           mrs_gap_q <= CNT_ONE;
            else if (mrs_gap_q != CNT_MAX) mrs_gap_q <= mrs_gap_q + CNT_ONE;
        end
    end

    // Rules that span all banks
    always_comb begin
        v_trrd = (cmd == CMD_ACT) && (act_gap_q < RRD_C);
        v_tmrd = (cmd != CMD_DESEL) && (cmd != CMD_NOP) && (mrs_gap_q < MRD_C);
        v_busy = ((cmd == CMD_REF) || (cmd == CMD_MRS)) && (|bk_open);
    end

    sdc_err_latch u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .v_state_i (|bk_state),
        .v_trcd_i  (|bk_trcd),
        .v_trrd_i  (v_trrd),
        .v_tras_i  (|bk_tras),
        .v_trp_i   (|bk_trp),
        .v_tmrd_i  (v_tmrd),
        .v_busy_i  (v_busy),
        .err_o     (err_o),
        .code_o    (err_code_o)
    );

    // R3
    pre_all_shuts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && a10_i) |=> (bk_open == '0));

    // R5
    act_gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |=> (act_gap_q == CNT_ONE));

endmodule

// File: tb/sim_sdram_cmd_checker.sv
module sim_sdram_cmd_checker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0, slow = 1'b0, cke = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [3:0] cmd;
    logic [7:0] bst;
    logic       err;
    logic [2:0] code;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    localparam logic [3:0] C_DES = 0, C_NOP = 1, C_ACT = 2, C_RD = 3,
                           C_WR = 4, C_PRE = 5, C_REF = 6, C_MRS = 7, C_BST = 8;

    always #4 clk = ~clk;

    sdram_cmd_checker u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .slow_i(slow), .cke_i(cke),
        .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
        .ba_i(ba), .a10_i(a10), .cmd_o(cmd), .bank_state_o(bst),
        .err_o(err), .err_code_o(code)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Put a command on the pins
    task automatic put(input logic [3:0] c, input logic [1:0] b, input logic a);
        ba = b; a10 = a; cs_n = 1'b0;
        case (c)
            C_DES: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
            C_ACT: {ras_n, cas_n, we_n} = 3'b011;
            C_RD:  {ras_n, cas_n, we_n} = 3'b101;
            C_WR:  {ras_n, cas_n, we_n} = 3'b100;
            C_PRE: {ras_n, cas_n, we_n} = 3'b010;
            C_REF: {ras_n, cas_n, we_n} = 3'b001;
            C_MRS: {ras_n, cas_n, we_n} = 3'b000;
            C_BST: {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic a);
        @(negedge clk);
        put(c, b, a);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 2'd0, 1'b0);
    endtask

    task automatic clear();
        @(negedge clk); put(C_NOP, 2'd0, 1'b0); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // Close all banks and clear the flag between scenarios
    task automatic park();
        slow = 1'b0;
        idle(8);
        issue(C_PRE, 2'd0, 1'b1);
        idle(4);
        clear();
    endtask

    task automatic t_reset();
        check("R2 reset banks", bst, 0);
        check("R12 reset flag", err, 0);
        check("R12 reset code", code, 0);
    endtask

    task automatic t_decode();
        for (int c = 0; c <= 8; c++) begin
            @(negedge clk);
            put(4'(c), 2'd0, 1'b0);
            #1 check("R1 decode", cmd, c);
            put(C_NOP, 2'd0, 1'b0);
        end
        @(negedge clk);
        cke = 1'b0; put(C_ACT, 2'd0, 1'b0);
        #1 check("R1 cke low is NOP", cmd, C_NOP);
        put(C_NOP, 2'd0, 1'b0); cke = 1'b1;
        #1 check("R1 no error from decode probes", err, 0);
    endtask

    task automatic t_legal();
        issue(C_ACT, 2'd0, 1'b0);
        check("R2 open", bst[1:0], 1);
        idle(2);
        issue(C_RD, 2'd0, 1'b0);
        issue(C_WR, 2'd0, 1'b0);
        issue(C_RD, 2'd0, 1'b0);
        issue(C_WR, 2'd0, 1'b0);
        check("R11 back-to-back column", err, 0);
        idle(2);
        issue(C_PRE, 2'd0, 1'b0);
        check("R2 closing", bst[1:0], 2);
        idle(2);
        check("R2 still closing", bst[1:0], 2);
        idle(1);
        check("R2 idle after tRP", bst[1:0], 0);
        check("R2 no error", err, 0);
        park();
    endtask

    task automatic t_trcd();
        issue(C_ACT, 2'd1, 1'b0);
        idle(1);
        issue(C_RD, 2'd1, 1'b0);
        check("R4 early read flag", err, 1);
        check("R4 early read code", code, 2);
        park();
        slow = 1'b1;
        issue(C_ACT, 2'd2, 1'b0);
        idle(1);
        issue(C_RD, 2'd2, 1'b0);
        check("R4 slow set read at 2", err, 0);
        issue(C_ACT, 2'd3, 1'b0);
        issue(C_WR, 2'd3, 1'b0);
        check("R4 slow set write at 1", code, 2);
        park();
    endtask

    task automatic t_trrd();
        issue(C_ACT, 2'd0, 1'b0);
        idle(1);
        issue(C_ACT, 2'd1, 1'b0);
        check("R5 gap of 2 legal", err, 0);
        park();
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_ACT, 2'd1, 1'b0);
        check("R5 gap of 1 code", code, 3);
        park();
    endtask

    task automatic t_tras();
        issue(C_ACT, 2'd0, 1'b0);
        idle(4);
        issue(C_PRE, 2'd0, 1'b0);
        check("R6 precharge at 5 code", code, 4);
        park();
        slow = 1'b1;
        issue(C_ACT, 2'd1, 1'b0);
        idle(4);
        issue(C_PRE, 2'd1, 1'b0);
        check("R6 slow set precharge at 5", err, 0);
        park();
    endtask

    task automatic t_trp();
        issue(C_ACT, 2'd1, 1'b0);
        idle(5);
        issue(C_PRE, 2'd1, 1'b0);
        idle(2);
        issue(C_ACT, 2'd1, 1'b0);
        check("R7 reopen at 3 legal", err, 0);
        park();
        issue(C_ACT, 2'd0, 1'b0);
        idle(5);
        issue(C_PRE, 2'd0, 1'b0);
        idle(1);
        issue(C_ACT, 2'd0, 1'b0);
        check("R7 reopen at 2 code", code, 5);
        park();
    endtask

    task automatic t_tmrd();
        issue(C_MRS, 2'd0, 1'b0);
        idle(1);
        issue(C_ACT, 2'd0, 1'b0);
        check("R8 command at 2 legal", err, 0);
        park();
        issue(C_MRS, 2'd0, 1'b0);
        issue(C_REF, 2'd0, 1'b0);
        check("R8 command at 1 code", code, 6);
        park();
    endtask

    task automatic t_state();
        issue(C_RD, 2'd2, 1'b0);
        check("R9 read idle bank", code, 1);
        park();
        issue(C_ACT, 2'd0, 1'b0);
        idle(2);
        issue(C_ACT, 2'd0, 1'b0);
        check("R9 reopen open bank", code, 1);
        park();
    endtask

    task automatic t_busy();
        issue(C_ACT, 2'd3, 1'b0);
        idle(1);
        issue(C_REF, 2'd0, 1'b0);
        check("R10 refresh with open bank", code, 7);
        park();
        issue(C_ACT, 2'd2, 1'b0);
        idle(2);
        issue(C_MRS, 2'd0, 1'b0);
        check("R10 mode set with open bank", code, 7);
        park();
    endtask

    task automatic t_prech();
        issue(C_ACT, 2'd0, 1'b0);
        idle(1);
        issue(C_ACT, 2'd1, 1'b0);
        idle(6);
        issue(C_PRE, 2'd0, 1'b0);
        check("R3 single bank closing", bst[1:0], 2);
        check("R3 other bank open", bst[3:2], 1);
        idle(4);
        issue(C_PRE, 2'd0, 1'b1);
        check("R3 all: bank1 closing", bst[3:2], 2);
        check("R3 all: bank0 idle", bst[1:0], 0);
        check("R3 no error", err, 0);
        park();
    endtask

    task automatic t_sticky();
        issue(C_RD, 2'd1, 1'b0);
        issue(C_ACT, 2'd0, 1'b0);
        issue(C_RD, 2'd0, 1'b0);
        idle(2);
        check("R12 flag held", err, 1);
        check("R12 first code kept", code, 1);
        clear();
        #1 check("R12 cleared flag", err, 0);
        check("R12 cleared code", code, 0);
        park();
        issue(C_MRS, 2'd0, 1'b0);
        issue(C_RD, 2'd0, 1'b0);
        check("R12 priority tMRD over state", code, 6);
        park();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        put(C_NOP, 2'd0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        t_reset();
        t_decode();
        t_legal();
        t_trcd();
        t_trrd();
        t_tras();
        t_trp();
        t_tmrd();
        t_state();
        t_busy();
        t_prech();
        t_sticky();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_bad, n_chk);
        $finish;
    end

endmodule